// File: doc/BRIEF.md
# Priority Filter Table Manager

This block owns a hashed receive-filter table and runs one management command at a time against it. An insert or remove command hashes its key to a start slot. It then probes the table one slot per clock, stepping by an odd increment derived from the key, until it finds a free slot, finds an entry with the same type and key, or has visited every slot. A clear command walks all slots in index order and frees each used entry whose priority does not exceed the priority given with the command.

Every entry carries a 2-bit priority. The values are hint = 0, manual = 1 and required = 2. A command may overwrite or delete an entry only when its own priority is at least the stored one. For each of the four filter types, the manager records the deepest probe chain that any insert of that type has needed. It presents these depths as search limits for the lookup hardware. A depth never shrinks while the table holds entries. Every change to a slot is sent out on a write port, so that a copy of the table can be kept alongside.

Top module: `filt_tbl_mgr`

## Requirements
- R1: An insert that lands on a used slot with the same type and key, with `cmd_replace` low, returns status 1 (exists) and changes nothing.
- R2: A replacing insert or a remove whose priority is below the stored entry's priority returns status 2 (permission). With equal or higher priority, the replace overwrites the entry, or the remove frees it, and returns status 0.
- R3: An insert that reaches a free slot marks it used, raises `occupancy` by one, issues a write of {type, priority, key} to that slot and returns status 0.
- R4: The search starts at the XOR of all `$clog2(SLOTS)`-bit slices of the key. It advances by (2 x key low slice - 1) modulo SLOTS. An entry matches only when both its type and its key are equal to the command's.
- R5: After a successful insert, the recorded depth for its type is raised to the number of slots probed, if that number is larger. Otherwise the depth is kept. `limit_upd` pulses when a depth is raised.
- R6: Clear (op 2; op 3 behaves the same) frees every used entry whose priority is less than or equal to the command priority, keeps the others, and returns status 0.
- R7: When a remove or a clear leaves `occupancy` at zero, all four recorded depths return to zero. At no other time does a depth decrease.
- R8: A remove that finds no match returns status 3 (not found). An insert that probes all SLOTS slots without finding a free or matching slot returns status 4 (full) and changes nothing.
- R9: Freeing a slot issues a write of an all-zero entry to that slot index.
- R10: `cmd_ready` is high only while idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. Each command produces exactly one single-cycle `rsp_valid` pulse.
- R11: After reset, `occupancy` and all depths are zero, `cmd_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Manager idle, command accepted |
| cmd_op | input | 2 | 0 insert, 1 remove, 2 or 3 clear |
| cmd_replace | input | 1 | Insert may overwrite a matching entry |
| cmd_type | input | 2 | Filter type |
| cmd_prio | input | 2 | Command priority (for clear: maximum priority freed) |
| cmd_key | input | KW | Match key |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 3 | 0 ok, 1 exists, 2 permission, 3 not found, 4 full |
| rsp_index | output | $clog2(SLOTS) | Slot that was resolved |
| wr_en | output | 1 | Table slot write strobe |
| wr_index | output | $clog2(SLOTS) | Slot written |
| wr_key | output | KW | Key written (zero on free) |
| wr_type | output | 2 | Type written (zero on free) |
| wr_prio | output | 2 | Priority written (zero on free) |
| occupancy | output | $clog2(SLOTS+1) | Number of used slots |
| srch_depth | output | 4*$clog2(SLOTS+1) | Recorded depth per type, type 0 in the low field |
| limit_upd | output | 1 | Pulse when a recorded depth was raised |

## Verification
The checker watches the properties that hold on every cycle. These are: occupancy stays within the table size, occupancy changes only together with a slot write, a depth falls only when the table is empty, responses are single pulses issued from the idle state, and the command port closes once a command is taken. The outcomes that depend on table contents can only be shown by the bench's scenarios. These are the status codes for each of the exists, permission, not-found and full cases, the probe chains that collisions build, and the priority cut made by a clear. The bench also shows what each write carries and the zeroing of the depths when the last entry leaves.

// File: rtl/filt_tbl_mgr.sv
module filt_tbl_mgr #(
  parameter int SLOTS = 16,
  parameter int KW    = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_valid,
  output logic                            cmd_ready,
  input  logic [1:0]                      cmd_op,
  input  logic                            cmd_replace,
  input  logic [1:0]                      cmd_type,
  input  logic [1:0]                      cmd_prio,
  input  logic [KW-1:0]                   cmd_key,
  output logic                            rsp_valid,
  output logic [2:0]                      rsp_status,
  output logic [$clog2(SLOTS)-1:0]        rsp_index,
  output logic                            wr_en,
  output logic [$clog2(SLOTS)-1:0]        wr_index,
  output logic [KW-1:0]                   wr_key,
  output logic [1:0]                      wr_type,
  output logic [1:0]                      wr_prio,
  output logic [$clog2(SLOTS+1)-1:0]      occupancy,
  output logic [4*$clog2(SLOTS+1)-1:0]    srch_depth,
  output logic                            limit_upd
);
  localparam int IW = $clog2(SLOTS);
  localparam int DW = $clog2(SLOTS+1);

  typedef enum logic [1:0] {S_IDLE, S_SRCH, S_CLR, S_CLRFIN} st_e;

  st_e           st;
  logic [1:0]    op_c, typ_c, pri_c;
  logic          rep_c;
  logic [KW-1:0] key_c;
  logic [IW-1:0] idx, inc;
  logic [DW-1:0] depth, cnt;
  logic [DW-1:0] lim [4];
  logic [SLOTS-1:0] used_q;
  logic [KW-1:0] key_q [SLOTS];
  logic [1:0]    typ_q [SLOTS];
  logic [1:0]    pri_q [SLOTS];

  function automatic logic [IW-1:0] fold(input logic [KW-1:0] k);
    logic [IW-1:0] h = '0;
    for (int i = 0; i < KW; i += IW) h ^= IW'(k >> i);
    return h;
  endfunction

  wire is_ins = (op_c == 2'd0);
  wire hit    = used_q[idx] && typ_q[idx] == typ_c && key_q[idx] == key_c;
  wire slot_free = !used_q[idx];

  assign cmd_ready = (st == S_IDLE);
  assign occupancy = cnt;
  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign srch_depth[g*DW +: DW] = lim[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_c <= '0; typ_c <= '0; pri_c <= '0; rep_c <= 1'b0; key_c <= '0;
      idx <= '0; inc <= '0; depth <= '0; cnt <= '0;
      used_q <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        key_q[i] <= '0; typ_q[i] <= '0; pri_q[i] <= '0;
      end
      for (int t = 0; t < 4; t++) lim[t] <= '0;
      rsp_valid <= 1'b0; rsp_status <= '0; rsp_index <= '0;
      wr_en <= 1'b0; wr_index <= '0; wr_key <= '0; wr_type <= '0; wr_prio <= '0;
      limit_upd <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      wr_en     <= 1'b0;
      limit_upd <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_c <= cmd_op; rep_c <= cmd_replace; typ_c <= cmd_type;
          pri_c <= cmd_prio; key_c <= cmd_key;
          depth <= DW'(1);
          inc <= IW'({cmd_key[IW-1:0], 1'b0} - 1);
          if (cmd_op[1]) begin
            idx <= '0;
            st  <= S_CLR;
          end else begin
            idx <= fold(cmd_key);
            st  <= S_SRCH;
          end
        end
        S_SRCH: begin
          if (slot_free || hit || depth == DW'(SLOTS)) begin
            st <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_index <= idx;
          end
          if (slot_free) begin
            if (is_ins) begin
              used_q[idx] <= 1'b1;
              cnt <= cnt + 1'b1;
              rsp_status <= 3'd0;
            end else rsp_status <= 3'd3;
          end else if (hit) begin
            if (is_ins && !rep_c) rsp_status <= 3'd1;
            else if (pri_c < pri_q[idx]) rsp_status <= 3'd2;
            else begin
              rsp_status <= 3'd0;
              if (!is_ins) begin
                used_q[idx] <= 1'b0;
                key_q[idx] <= '0; typ_q[idx] <= '0; pri_q[idx] <= '0;
                wr_en <= 1'b1; wr_index <= idx;
                wr_key <= '0; wr_type <= '0; wr_prio <= '0;
                cnt <= cnt - 1'b1;
                if (cnt == DW'(1)) for (int t = 0; t < 4; t++) lim[t] <= '0;
              end
            end
          end else if (depth == DW'(SLOTS)) begin
            rsp_status <= is_ins ? 3'd4 : 3'd3;
          end else begin
            idx <= idx + inc;
            depth <= depth + 1'b1;
          end
          if (is_ins && (slot_free || (hit && rep_c && pri_c >= pri_q[idx]))) begin
            key_q[idx] <= key_c; typ_q[idx] <= typ_c; pri_q[idx] <= pri_c;
            wr_en <= 1'b1; wr_index <= idx;
            wr_key <= key_c; wr_type <= typ_c; wr_prio <= pri_c;
            if (depth > lim[typ_c]) begin
              lim[typ_c] <= depth;
              limit_upd <= 1'b1;
            end
          end
        end
        S_CLR: begin
          if (used_q[idx] && pri_q[idx] <= pri_c) begin
            used_q[idx] <= 1'b0;
            key_q[idx] <= '0; typ_q[idx] <= '0; pri_q[idx] <= '0;
            wr_en <= 1'b1; wr_index <= idx;
            wr_key <= '0; wr_type <= '0; wr_prio <= '0;
            cnt <= cnt - 1'b1;
          end
          if (idx == IW'(SLOTS-1)) st <= S_CLRFIN;
          else idx <= idx + 1'b1;
        end
        default: begin
          if (cnt == '0) for (int t = 0; t < 4; t++) lim[t] <= '0;
          rsp_valid <= 1'b1;
          rsp_status <= 3'd0;
          rsp_index <= '0;
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module filt_tbl_mgr_chk #(
  parameter int SLOTS = 16,
  parameter int DW    = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic            rsp_valid,
  input logic            wr_en,
  input logic [DW-1:0]   occupancy,
  input logic [4*DW-1:0] srch_depth
);
  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= DW'(SLOTS));
  // R3
  occ_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy != $past(occupancy)) |-> wr_en);
  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cmd_ready);
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  for (genvar g = 0; g < 4; g++) begin : g_dep
    // R7
    depth_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_depth[g*DW +: DW] < $past(srch_depth[g*DW +: DW])) |-> occupancy == '0);
  end
endmodule

bind filt_tbl_mgr filt_tbl_mgr_chk #(.SLOTS(SLOTS), .DW($clog2(SLOTS+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .wr_en(wr_en), .occupancy(occupancy),
  .srch_depth(srch_depth)
);

// File: tb/test_filt_tbl_mgr.sv
module test_filt_tbl_mgr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_replace = 1'b0;
  logic [1:0] cmd_op = '0, cmd_type = '0, cmd_prio = '0;
  logic [15:0] cmd_key = '0;
  logic cmd_ready, rsp_valid, wr_en, limit_upd;
  logic [2:0] rsp_status;
  logic [3:0] rsp_index, wr_index;
  logic [15:0] wr_key;
  logic [1:0] wr_type, wr_prio;
  logic [4:0] occupancy;
  logic [19:0] srch_depth;

  int checks = 0, fails = 0;
  logic [3:0] lw_idx;
  logic [15:0] lw_key;
  logic [1:0] lw_typ, lw_pri;
  logic [2:0] got_st;

  always #10 clk = ~clk;

  filt_tbl_mgr #(.SLOTS(16), .KW(16)) i_filt_tbl_mgr (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_replace(cmd_replace), .cmd_type(cmd_type),
    .cmd_prio(cmd_prio), .cmd_key(cmd_key), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_index(rsp_index), .wr_en(wr_en),
    .wr_index(wr_index), .wr_key(wr_key), .wr_type(wr_type), .wr_prio(wr_prio),
    .occupancy(occupancy), .srch_depth(srch_depth), .limit_upd(limit_upd)
  );

  always @(negedge clk) if (wr_en) begin
    lw_idx <= wr_index; lw_key <= wr_key; lw_typ <= wr_type; lw_pri <= wr_prio;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic rep, input logic [1:0] ty,
                     input logic [1:0] pr, input logic [15:0] key);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_replace = rep;
    cmd_type = ty; cmd_prio = pr; cmd_key = key;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 ready low while busy", int'(cmd_ready), 0);
    while (!rsp_valid) @(negedge clk);
    got_st = rsp_status;
  endtask

  typedef struct packed {
    logic [1:0] op; logic rep; logic [1:0] ty; logic [1:0] pr; logic [15:0] key;
    logic [2:0] st; logic [4:0] cnt; logic [4:0] d0; logic [4:0] d1;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{2'd0, 1'b0, 2'd0, 2'd1, 16'h0001, 3'd0, 5'd1, 5'd1, 5'd0}, // R3 R4 R5
    '{2'd0, 1'b0, 2'd0, 2'd1, 16'h0001, 3'd1, 5'd1, 5'd1, 5'd0}, // R1
    '{2'd0, 1'b1, 2'd0, 2'd0, 16'h0001, 3'd2, 5'd1, 5'd1, 5'd0}, // R2
    '{2'd0, 1'b1, 2'd0, 2'd2, 16'h0001, 3'd0, 5'd1, 5'd1, 5'd0}, // R2 replace
    '{2'd0, 1'b0, 2'd0, 2'd1, 16'h0010, 3'd0, 5'd2, 5'd2, 5'd0}, // R4 R5 collision
    '{2'd0, 1'b0, 2'd1, 2'd0, 16'h0001, 3'd0, 5'd3, 5'd2, 5'd2}, // R4 type differs
    '{2'd1, 1'b0, 2'd0, 2'd1, 16'h0001, 3'd2, 5'd3, 5'd2, 5'd2}, // R2 remove
    '{2'd1, 1'b0, 2'd0, 2'd0, 16'h0100, 3'd3, 5'd3, 5'd2, 5'd2}, // R8
    '{2'd1, 1'b0, 2'd1, 2'd0, 16'h0001, 3'd0, 5'd2, 5'd2, 5'd2}, // R2 R7 not empty
    '{2'd2, 1'b0, 2'd0, 2'd1, 16'h0000, 3'd0, 5'd1, 5'd2, 5'd2}, // R6
    '{2'd1, 1'b0, 2'd0, 2'd2, 16'h0001, 3'd0, 5'd0, 5'd0, 5'd0}  // R6 R7 R9
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=response");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 occupancy", int'(occupancy), 0);
    chk("R11 depth", int'(srch_depth), 0);
    chk("R11 ready", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 rsp_valid", int'(rsp_valid), 0);

    for (int i = 0; i < 11; i++) begin
      run(VEC[i].op, VEC[i].rep, VEC[i].ty, VEC[i].pr, VEC[i].key);
      chk($sformatf("vec%0d status", i), int'(got_st), int'(VEC[i].st));
      chk($sformatf("vec%0d occupancy", i), int'(occupancy), int'(VEC[i].cnt));
      chk($sformatf("vec%0d R5 depth t0", i), int'(srch_depth[4:0]), int'(VEC[i].d0));
      chk($sformatf("vec%0d R5 depth t1", i), int'(srch_depth[9:5]), int'(VEC[i].d1));
      @(negedge clk);
      chk("R10 single pulse", int'(rsp_valid), 0);
      if (i == 4) begin
        chk("R3 write index", int'(lw_idx), 0);
        chk("R3 write key", int'(lw_key), 16'h0010);
        chk("R3 write prio", int'(lw_pri), 1);
        chk("R3 write type", int'(lw_typ), 0);
      end
      if (i == 10) begin
        chk("R9 zero write index", int'(lw_idx), 1);
        chk("R9 zero write key", int'(lw_key), 0);
        chk("R9 zero write prio", int'(lw_pri), 0);
      end
    end

    for (int k = 0; k < 16; k++) begin
      run(2'd0, 1'b0, 2'd2, 2'd0, 16'(k));
      chk("R3 fill", int'(got_st), 0);
      chk("R4 fill slot", int'(rsp_index), k);
    end
    chk("R3 full occupancy", int'(occupancy), 16);
    run(2'd0, 1'b0, 2'd2, 2'd0, 16'h0010);
    chk("R8 full status", int'(got_st), 4);
    chk("R8 full occupancy", int'(occupancy), 16);
    chk("R5 depth t2 kept", int'(srch_depth[14:10]), 1);
    run(2'd3, 1'b0, 2'd0, 2'd0, 16'h0000);
    chk("R6 clear all status", int'(got_st), 0);
    chk("R6 clear all occupancy", int'(occupancy), 0);
    chk("R7 depths zero", int'(srch_depth), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule